// File: doc/BRIEF.md
# Constant Off-Time Current Limiter

This block is the digital regulation controller for one H-bridge. Two comparator flags come in from the analog side: one for the low-side current-limit threshold and one for the short-circuit threshold. When the current-limit flag is seen while the bridge is running normally, the block asks for the bridge to be tristated for a fixed off interval. After that interval the bridge is enabled again. Every output activation, whether it comes from outside or from the end of an off interval, opens a blanking window. During that window the limit flag is ignored. A short-circuit flag seen inside the window latches the bridge off until reset; it does not start regulation.

All durations are counted in ticks of a clock-enable input and come from parameters given in nanoseconds. A rate guard keeps successive off intervals a minimum period apart, so the regulation rate never exceeds a set ceiling (20 kHz by default). A fold-back calculator turns an 8-bit junction-temperature code into the threshold code for the external DAC that feeds the limit comparator. The code stays at its nominal level up to a knee temperature and then falls linearly to a floor at a trip temperature. Above the trip temperature the block raises an over-temperature request.

Top module: `offtime_limiter`

## Requirements
- R1: While reset is held, and after it is released with no stimulus, forceTristate, shortFaultReq and overTempReq are 0 and limitThreshCode equals CODE_NOM.
- R2: The limit flag passes through a two-flop synchronizer, and a single-cycle pulse of it is enough. If the synchronized flag is seen while running outside any blanking window and the rate guard is clear, forceTristate rises after the third rising clock edge that follows the input change.
- R3: forceTristate stays high for exactly OFF_TICKS ticks of tickEn and then falls. The release itself opens a new blanking window.
- R4: activateStrobe opens a blanking window of BLANK_TICKS ticks. A synchronized limit flag seen inside the window is ignored. A strobe given while the window is open restarts the window. A strobe given during an off interval has no effect on that interval.
- R5: A synchronized short flag seen while a blanking window is open raises forceTristate and shortFaultReq together. Both then stay high until reset, whatever the other inputs do.
- R6: A short flag seen outside a blanking window, including during an off interval, has no effect.
- R7: Successive off intervals start at least PERIOD_TICKS ticks apart. With the limit flag held high, they start exactly PERIOD_TICKS ticks apart.
- R8: One cycle after tempCode changes, limitThreshCode reflects it as follows. For T <= TEMP_KNEE it is CODE_NOM. For T >= TEMP_TRIP it is CODE_FLOOR. Between the two it is CODE_NOM - floor((CODE_NOM-CODE_FLOOR)*(T-TEMP_KNEE)/(TEMP_TRIP-TEMP_KNEE)), where T is tempCode read as unsigned degrees Celsius.
- R9: One cycle after tempCode changes, overTempReq is 1 exactly when T > TEMP_TRIP.
- R10: The off, blanking and guard counters advance only on cycles where tickEn is 1, so durations scale with the tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Time-base tick that advances all duration counters |
| activateStrobe | input | 1 | One-cycle pulse when the bridge outputs are switched on |
| limitCmp | input | 1 | Low-side current-limit comparator flag (asynchronous) |
| shortCmp | input | 1 | Short-circuit comparator flag (asynchronous) |
| tempCode | input | TEMP_W | Junction temperature in degrees Celsius |
| forceTristate | output | 1 | Request to switch all bridge transistors off |
| shortFaultReq | output | 1 | Latched short-circuit fault request |
| overTempReq | output | 1 | Over-temperature latch-off request |
| limitThreshCode | output | CODE_W | Limit threshold code for the external DAC |

## Verification
The bench builds the block with a 500 ns tick, a 2000 ns off time, a 1500 ns blanking window and a 5000 ns guard period. That gives 4, 3 and 10 ticks, so every cycle offset of a limit or short pulse relative to an activation can be swept across the whole window and a little beyond it. Within those sweeps the window edge, where the synchronizer delay meets the blanking count, shows up as a clean change between ignore and act, and between latch and no-effect. The fold-back keeps its default knee, trip and codes, and all 256 temperature codes are swept against the integer formula. One run slows tickEn to one cycle in three to show that durations are measured in ticks.

// File: rtl/offtime_pkg.sv
package offtime_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_BLANK = 2'd1,
    ST_OFF   = 2'd2,
    ST_LATCH = 2'd3
  } limState_t;

  // control -> datapath
  typedef struct packed {
    logic loadOff;
    logic loadBlank;
    logic loadGuard;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic limitHit;
    logic shortHit;
    logic offDone;
    logic blankDone;
    logic guardClear;
  } dpFlag_t;

endpackage

// File: rtl/offtime_sync2.sv
module offtime_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

endmodule

// File: rtl/offtime_datapath.sv
module offtime_datapath
  import offtime_pkg::*;
#(
  parameter int OFF_TICKS    = 40,
  parameter int BLANK_TICKS  = 33,
  parameter int PERIOD_TICKS = 100,
  parameter int TEMP_KNEE    = 160,
  parameter int TEMP_TRIP    = 175,
  parameter int CODE_NOM     = 130,
  parameter int CODE_FLOOR   = 80,
  parameter int TEMP_W       = 8,
  parameter int CODE_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              limitRaw,
  input  logic              shortRaw,
  input  logic [TEMP_W-1:0] tempCode,
  input  ctlStrobe_t        strobe,
  output dpFlag_t           flags,
  output logic [CODE_W-1:0] threshCode,
  output logic              overTempReq
);

  localparam int OFF_W      = $clog2(OFF_TICKS + 1);
  localparam int BLANK_W    = $clog2(BLANK_TICKS + 1);
  localparam int GUARD_LOAD = PERIOD_TICKS - 1;
  localparam int GUARD_W    = $clog2(PERIOD_TICKS + 1);
  localparam int TEMP_SPAN  = TEMP_TRIP - TEMP_KNEE;
  localparam int CODE_SPAN  = CODE_NOM - CODE_FLOOR;

  logic [1:0]         syncOut;
  logic [OFF_W-1:0]   offCnt;
  logic [BLANK_W-1:0] blankCnt;
  logic [GUARD_W-1:0] guardCnt;
  int                 tempVal;
  int                 foldVal;
  logic [CODE_W-1:0]  threshNext;

  offtime_sync2 #(.WIDTH(2)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({limitRaw, shortRaw}),
    .dout (syncOut)
  );

  // off-interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      offCnt <= '0;
    else if (strobe.loadOff)        offCnt <= OFF_W'(OFF_TICKS);
    else if (tickEn && offCnt != 0) offCnt <= offCnt - 1'b1;
  end

  // blanking-window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        blankCnt <= '0;
    else if (strobe.loadBlank)        blankCnt <= BLANK_W'(BLANK_TICKS);
    else if (tickEn && blankCnt != 0) blankCnt <= blankCnt - 1'b1;
  end

  // rate guard: counts down from each off-interval start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        guardCnt <= '0;
    else if (strobe.loadGuard)        guardCnt <= GUARD_W'(GUARD_LOAD);
    else if (tickEn && guardCnt != 0) guardCnt <= guardCnt - 1'b1;
  end

  always_comb begin
    flags.limitHit   = syncOut[1];
    flags.shortHit   = syncOut[0];
    flags.offDone    = tickEn && (offCnt == OFF_W'(1));
    flags.blankDone  = tickEn && (blankCnt == BLANK_W'(1));
    flags.guardClear = (guardCnt == '0);
  end

  // temperature fold-back of the limit threshold
  always_comb begin
    tempVal = int'(tempCode);
    if (tempVal <= TEMP_KNEE)      foldVal = CODE_NOM;
    else if (tempVal >= TEMP_TRIP) foldVal = CODE_FLOOR;
    else foldVal = CODE_NOM - (CODE_SPAN * (tempVal - TEMP_KNEE)) / TEMP_SPAN;
    threshNext = CODE_W'(foldVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      threshCode  <= CODE_W'(CODE_NOM);
      overTempReq <= 1'b0;
    end else begin
      threshCode  <= threshNext;
      overTempReq <= (tempVal > TEMP_TRIP);
    end
  end

  assert_guard_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    int'(guardCnt) <= GUARD_LOAD);

  assert_thresh_span_R8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(threshCode) <= CODE_NOM) && (int'(threshCode) >= CODE_FLOOR));

  assert_overtemp_floor_R9: assert property (@(posedge clk) disable iff (!rstN)
    overTempReq |-> (threshCode == CODE_W'(CODE_FLOOR)));

endmodule

// File: rtl/offtime_ctrl.sv
module offtime_ctrl
  import offtime_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       activate,
  input  dpFlag_t    flags,
  output ctlStrobe_t strobe,
  output logic       forceTristate,
  output logic       shortFault
);

  limState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_RUN: begin
        if (activate) begin
          stateNext        = ST_BLANK;
          strobe.loadBlank = 1'b1;
        end else if (flags.limitHit && flags.guardClear) begin
          stateNext        = ST_OFF;
          strobe.loadOff   = 1'b1;
          strobe.loadGuard = 1'b1;
        end
      end
      ST_BLANK: begin
        if (flags.shortHit) begin
          stateNext = ST_LATCH;
        end else if (activate) begin
          strobe.loadBlank = 1'b1;
        end else if (flags.blankDone) begin
          stateNext = ST_RUN;
        end
      end
      ST_OFF: begin
        if (flags.offDone) begin
          stateNext        = ST_BLANK;
          strobe.loadBlank = 1'b1;
        end
      end
      ST_LATCH: stateNext = ST_LATCH;
      default:  stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign forceTristate = (state == ST_OFF) || (state == ST_LATCH);
  assign shortFault    = (state == ST_LATCH);

  assert_latch_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LATCH) |=> (state == ST_LATCH));

  assert_window_no_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BLANK) |=> (state != ST_OFF));

  assert_off_needs_guard_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_OFF) |-> $past(flags.guardClear));

  assert_off_from_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_OFF) |-> ($past(state) == ST_RUN) && $past(flags.limitHit));

endmodule

// File: rtl/offtime_limiter.sv
module offtime_limiter
  import offtime_pkg::*;
#(
  parameter int TICK_NS    = 500,
  parameter int OFF_NS     = 20000,
  parameter int BLANK_NS   = 16500,
  parameter int PERIOD_NS  = 50000,
  parameter int TEMP_KNEE  = 160,
  parameter int TEMP_TRIP  = 175,
  parameter int CODE_NOM   = 130,
  parameter int CODE_FLOOR = 80,
  parameter int TEMP_W     = 8,
  parameter int CODE_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              activateStrobe,
  input  logic              limitCmp,
  input  logic              shortCmp,
  input  logic [TEMP_W-1:0] tempCode,
  output logic              forceTristate,
  output logic              shortFaultReq,
  output logic              overTempReq,
  output logic [CODE_W-1:0] limitThreshCode
);

  localparam int OFF_TICKS    = OFF_NS / TICK_NS;
  localparam int BLANK_TICKS  = BLANK_NS / TICK_NS;
  localparam int PERIOD_TICKS = PERIOD_NS / TICK_NS;

  ctlStrobe_t strobe;
  dpFlag_t    flags;

  offtime_datapath #(
    .OFF_TICKS    (OFF_TICKS),
    .BLANK_TICKS  (BLANK_TICKS),
    .PERIOD_TICKS (PERIOD_TICKS),
    .TEMP_KNEE    (TEMP_KNEE),
    .TEMP_TRIP    (TEMP_TRIP),
    .CODE_NOM     (CODE_NOM),
    .CODE_FLOOR   (CODE_FLOOR),
    .TEMP_W       (TEMP_W),
    .CODE_W       (CODE_W)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .limitRaw    (limitCmp),
    .shortRaw    (shortCmp),
    .tempCode    (tempCode),
    .strobe      (strobe),
    .flags       (flags),
    .threshCode  (limitThreshCode),
    .overTempReq (overTempReq)
  );

  offtime_ctrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .activate      (activateStrobe),
    .flags         (flags),
    .strobe        (strobe),
    .forceTristate (forceTristate),
    .shortFault    (shortFaultReq)
  );

endmodule

// File: tb/offtime_limiter_test.sv
module offtime_limiter_test;

  localparam int TICK_NS = 500, OFF_NS = 2000, BLANK_NS = 1500, PERIOD_NS = 5000;
  localparam int OFF_T = OFF_NS / TICK_NS;       // 4
  localparam int BLANK_T = BLANK_NS / TICK_NS;   // 3
  localparam int PERIOD_T = PERIOD_NS / TICK_NS; // 10
  localparam int KNEE = 160, TRIP = 175, NOM = 130, FLOOR = 80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic activateStrobe = 1'b0;
  logic limitCmp = 1'b0;
  logic shortCmp = 1'b0;
  logic [7:0] tempCode = 8'd25;
  logic forceTristate, shortFaultReq, overTempReq;
  logic [7:0] limitThreshCode;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  offtime_limiter #(
    .TICK_NS(TICK_NS), .OFF_NS(OFF_NS), .BLANK_NS(BLANK_NS), .PERIOD_NS(PERIOD_NS),
    .TEMP_KNEE(KNEE), .TEMP_TRIP(TRIP), .CODE_NOM(NOM), .CODE_FLOOR(FLOOR),
    .TEMP_W(8), .CODE_W(8)
  ) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .activateStrobe(activateStrobe),
    .limitCmp(limitCmp), .shortCmp(shortCmp), .tempCode(tempCode),
    .forceTristate(forceTristate), .shortFaultReq(shortFaultReq),
    .overTempReq(overTempReq), .limitThreshCode(limitThreshCode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    activateStrobe = 1'b0; limitCmp = 1'b0; shortCmp = 1'b0; tickEn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic int foldExp(input int t);
    if (t <= KNEE) return NOM;
    if (t >= TRIP) return FLOOR;
    return NOM - ((NOM - FLOOR) * (t - KNEE)) / (TRIP - KNEE);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 forceTristate in reset", int'(forceTristate), 0);
    chk("R1 threshold in reset", int'(limitThreshCode), NOM);
    doReset();
    @(negedge clk);
    chk("R1 forceTristate", int'(forceTristate), 0);
    chk("R1 shortFaultReq", int'(shortFaultReq), 0);
    chk("R1 overTempReq", int'(overTempReq), 0);
    chk("R1 threshold", int'(limitThreshCode), NOM);

    // R2 R3 R4: limit pulse at offset d from an activation
    for (int d = 0; d <= 6; d++) begin
      int first, cnt, expFirst, expCnt;
      doReset();
      activateStrobe = 1'b1; limitCmp = (d == 0);
      first = -1; cnt = 0;
      for (int j = 1; j <= 20; j++) begin
        @(negedge clk);
        if (forceTristate) begin cnt++; if (first < 0) first = j; end
        activateStrobe = 1'b0; limitCmp = (j == d);
      end
      expFirst = (d + 2 > BLANK_T) ? d + 3 : -1;
      expCnt   = (d + 2 > BLANK_T) ? OFF_T : 0;
      chk($sformatf("R2 R4 limit offset %0d first high", d), first, expFirst);
      chk($sformatf("R3 limit offset %0d off length", d), cnt, expCnt);
    end

    // R5 R6: short pulse at offset d from an activation
    for (int d = 0; d <= 6; d++) begin
      int first, expFirst;
      doReset();
      activateStrobe = 1'b1; shortCmp = (d == 0);
      first = -1;
      for (int j = 1; j <= 20; j++) begin
        @(negedge clk);
        if (forceTristate && first < 0) first = j;
        activateStrobe = 1'b0; shortCmp = (j == d);
        if (j == 12) limitCmp = 1'b1;
        if (j == 14) activateStrobe = 1'b1;
      end
      limitCmp = 1'b0;
      @(negedge clk);
      expFirst = (d + 2 <= BLANK_T) ? d + 3 : -1;
      if (d + 2 <= BLANK_T) begin
        chk($sformatf("R5 short offset %0d latch time", d), first, expFirst);
        chk($sformatf("R5 short offset %0d fault sticky", d), int'(shortFaultReq), 1);
        chk($sformatf("R5 short offset %0d tristate sticky", d), int'(forceTristate), 1);
      end else begin
        chk($sformatf("R6 short offset %0d no fault", d), int'(shortFaultReq), 0);
      end
    end

    // R4 restart: second activation extends the window past a limit pulse
    begin
      int cnt;
      doReset();
      activateStrobe = 1'b1; cnt = 0;
      for (int j = 1; j <= 15; j++) begin
        @(negedge clk);
        if (forceTristate) cnt++;
        activateStrobe = (j == 2);
        limitCmp = (j == 2);
      end
      chk("R4 restarted window masks limit", cnt, 0);
    end

    // R4 R6: activation and short during an off interval are ignored
    begin
      int cnt, first;
      doReset();
      limitCmp = 1'b1; cnt = 0; first = -1;
      for (int j = 1; j <= 15; j++) begin
        @(negedge clk);
        if (forceTristate) begin cnt++; if (first < 0) first = j; end
        limitCmp = 1'b0;
        activateStrobe = (j == 4);
        shortCmp = (j == 3);
      end
      chk("R4 activation in off interval: start", first, 3);
      chk("R4 activation in off interval: length", cnt, OFF_T);
      chk("R6 short in off interval ignored", int'(shortFaultReq), 0);
    end

    // R7: limit held high, regulation period
    begin
      int bad;
      doReset();
      limitCmp = 1'b1; bad = 0;
      for (int j = 1; j <= 40; j++) begin
        int exp;
        @(negedge clk);
        exp = (j >= 3 && ((j - 3) % PERIOD_T) < OFF_T) ? 1 : 0;
        chk($sformatf("R7 held limit cycle %0d", j), int'(forceTristate), exp);
      end
      limitCmp = 1'b0;
    end

    // R10: slow tick, off interval counted in ticks
    begin
      int tickedHigh, totalHigh;
      doReset();
      limitCmp = 1'b1; tickedHigh = 0; totalHigh = 0;
      for (int j = 1; j <= 60; j++) begin
        logic ft;
        @(negedge clk);
        ft = forceTristate;
        limitCmp = 1'b0;
        tickEn = ((j % 3) == 0);
        if (ft) totalHigh++;
        if (ft && tickEn) tickedHigh++;
      end
      tickEn = 1'b1;
      chk("R10 ticks during off interval", tickedHigh, OFF_T);
      chk("R10 off interval stretched", int'(totalHigh > OFF_T), 1);
    end

    // R8 R9: full temperature sweep
    doReset();
    for (int t = 0; t < 256; t++) begin
      tempCode = 8'(t);
      @(negedge clk);
      chk($sformatf("R8 threshold at %0d C", t), int'(limitThreshCode), foldExp(t));
      chk($sformatf("R9 overtemp at %0d C", t), int'(overTempReq), (t > TRIP) ? 1 : 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule